// File: doc/BRIEF.md
# Edge-Detecting GPIO Interrupt Controller

This block is a 28-pin general-purpose I/O controller with per-pin edge detection and a compact word-addressed register interface (address, write data, write strobe, combinational read data). Software picks each pin's direction, drives output levels through separate set and clear registers, reads the synchronized input levels, and selects which edge or edges of each pin are recorded in a sticky status register. Software clears that register by writing ones.

The status bits drive twelve interrupt lines. Pins 0 to 10 each have a line of their own. The status bits of pins 11 to 27 are ORed onto line 11, so a handler for that line reads the status word to find the source pin. An alternate-function select per pin hands that pin's output enable and output data to a bypass path coming from another peripheral.

Each register word holds one bit per pin, with pin n at bit n. Bits 28 to 31 always read as 0.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0, every pin is an input (pin_oe = 0), the output latch is 0 (pin_out = 0) and irq = 0.
- R2: Word addresses: 0 level (read only), 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate select. Direction, both enables and alternate select read back what was written, with bits 28 to 31 forced to 0. Set and clear read as 0. Addresses 8 to 15 read 0, and writes to them have no effect.
- R3: A write to the set register sets the output latch bits where the data bit is 1. A write to the clear register clears them where the data bit is 1. Bits written as 0 leave the latch unchanged.
- R4: For a pin with alternate select 0, pin_oe equals its direction bit (1 = output) and pin_out equals its latch bit.
- R5: For a pin with alternate select 1, pin_oe follows alt_oe and pin_out follows alt_out for that pin.
- R6: The level register returns pin_in after a two-flop synchronizer, so it is readable from the second rising clock edge after the input changes.
- R7: A 0-to-1 change on a pin whose rising enable is 1, or a 1-to-0 change on a pin whose falling enable is 1, sets that pin's status bit on the third rising edge after the input change. With both enables set, both kinds of change are recorded.
- R8: An edge on a pin whose matching enable is 0 is not recorded. Clearing an enable does not clear a status bit that is already set.
- R9: Writing the status register clears exactly the bits written as 1. Writing 0 changes nothing.
- R10: When an edge is detected in the same cycle that software clears that pin's status bit, the bit stays set.
- R11: irq[i] equals status bit i for i = 0 to 10.
- R12: irq[11] is 1 exactly when any status bit for pins 11 to 27 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 28 | Pad input levels (asynchronous) |
| pin_out | output | 28 | Pad output data |
| pin_oe | output | 28 | Pad output enable, 1 = drive |
| alt_out | input | 28 | Output data from the alternate function |
| alt_oe | input | 28 | Output enable from the alternate function |
| irq | output | 12 | Interrupt lines: 0 to 10 per pin, 11 shared by pins 11 to 27 |

## Verification
The edge logic is swept over every pin and all four enable settings (none, rising, falling, both). Each pin gets a rise followed by a fall, and the status word and the irq vector are checked after each change. This separates the two enables, shows that a disabled edge leaves no trace, and shows that the dedicated lines and the shared line go to the right pins, including the boundary pins 10, 11 and 27.

The set and clear registers are tried with patterns that overlap, with zero masks and with a write to the wrong register, which separates set from clear from no effect. Mixed direction and alternate-select patterns show which path drives each pad. A fall that lands in the same cycle as the clear write shows that a new edge wins over the clear, and writes of partial masks and of zero show the write-one-to-clear rule.

// File: rtl/gpio_ctrl_pkg.sv
// Package: shared definitions for the edge-detecting GPIO controller.
// Assumes a word-addressed register interface, one bit per pin in each word.
package gpio_ctrl_pkg;

    // Register index, taken from the low three bits of the word address.
    typedef enum logic [2:0] {
        REG_LEVEL = 3'd0,
        REG_DIR   = 3'd1,
        REG_SET   = 3'd2,
        REG_CLR   = 3'd3,
        REG_RISE  = 3'd4,
        REG_FALL  = 3'd5,
        REG_STAT  = 3'd6,
        REG_ALT   = 3'd7
    } gpio_reg_e;

    // One write strobe per writable register.
    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic stat;
        logic alt;
    } gpio_wr_sel_t;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchronizer for every pad input.
// Assumes the inputs may change at any time relative to clk.
module gpio_in_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Purpose: move the pad levels into the clk domain in two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/gpio_edge_capture.sv
// Module: gpio_edge_capture
// Finds the enabled edges on the synchronized levels and keeps them in a
// sticky status word that software clears by writing ones.
// Assumes the levels are already synchronous. A new edge takes priority over
// a clear in the same cycle.
module gpio_edge_capture #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] edge_evt,
    output logic [WIDTH-1:0] status
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] rise_hit;
    logic [WIDTH-1:0] fall_hit;
    logic [WIDTH-1:0] keep_mask;

    // Purpose: hold the previous synchronized level for the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Purpose: find the enabled rising and falling transitions in this cycle.
    always_comb begin
        rise_hit = level & ~prev_q & rise_en;
        fall_hit = ~level & prev_q & fall_en;
        edge_evt = rise_hit | fall_hit;
    end

    // Purpose: bits written as one are cleared, all others are kept.
    always_comb begin
        keep_mask = clr_we ? ~clr_mask : '1;
    end

    // Purpose: sticky status; an edge in this cycle overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & keep_mask) | edge_evt;
    end

    assign status = status_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds direction, edge enables, alternate select and the output latch.
// Assumes the write strobes are already decoded and one-hot.
module gpio_cfg_regs #(
    parameter int WIDTH = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  gpio_ctrl_pkg::gpio_wr_sel_t wr_sel,
    input  logic [WIDTH-1:0]           wdata,
    output logic [WIDTH-1:0]           dir,
    output logic [WIDTH-1:0]           rise_en,
    output logic [WIDTH-1:0]           fall_en,
    output logic [WIDTH-1:0]           alt_sel,
    output logic [WIDTH-1:0]           out_latch
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;
    logic [WIDTH-1:0] alt_q;
    logic [WIDTH-1:0] latch_q;

    // Purpose: plain read/write configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            alt_q  <= '0;
        end else begin
            if (wr_sel.dir)  dir_q  <= wdata;
            if (wr_sel.rise) rise_q <= wdata;
            if (wr_sel.fall) fall_q <= wdata;
            if (wr_sel.alt)  alt_q  <= wdata;
        end
    end

    // Purpose: output latch, set and cleared bit by bit through masks.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (wr_sel.set) latch_q <= latch_q | wdata;
        else if (wr_sel.clr) latch_q <= latch_q & ~wdata;
    end

    assign dir       = dir_q;
    assign rise_en   = rise_q;
    assign fall_en   = fall_q;
    assign alt_sel   = alt_q;
    assign out_latch = latch_q;

endmodule

// File: rtl/gpio_irq_fanin.sv
// Module: gpio_irq_fanin
// Maps the status word onto the interrupt lines: one line for each of the
// low pins, and one shared OR line for all remaining pins.
// Assumes WIDTH > NUM_DIRECT.
module gpio_irq_fanin #(
    parameter int WIDTH      = 28,
    parameter int NUM_DIRECT = 11
) (
    input  logic [WIDTH-1:0]    status,
    output logic [NUM_DIRECT:0] irq
);

    // Purpose: each low pin gets a line of its own.
    for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
        assign irq[i] = status[i];
    end

    // Purpose: the upper pins share the last line.
    assign irq[NUM_DIRECT] = |status[WIDTH-1:NUM_DIRECT];

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
// Module: gpio_edge_irq_ctrl (top)
// GPIO controller with per-pin edge capture, write-one-to-clear status,
// interrupt lines and an alternate-function bypass of the pad controls.
// Assumes ADDR_W >= 4 and DATA_W >= NUM_PINS. Reads are combinational;
// writes take effect on the rising edge where bus_we is high.
module gpio_edge_irq_ctrl #(
    parameter int NUM_PINS   = 28,
    parameter int NUM_DIRECT = 11,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    input  logic [NUM_PINS-1:0]   alt_out,
    input  logic [NUM_PINS-1:0]   alt_oe,
    output logic [NUM_DIRECT:0]   irq
);
    import gpio_ctrl_pkg::*;

    localparam int IDX_W   = 3;
    localparam int NUM_IRQ = NUM_DIRECT + 1;

    logic                    addr_ok;
    gpio_reg_e               reg_idx;
    gpio_wr_sel_t            wr_sel;
    logic [NUM_PINS-1:0]     wdata_pins;
    logic                    unused_wdata_hi;

    logic [NUM_PINS-1:0]     lvl_sync;
    logic [NUM_PINS-1:0]     dir_q;
    logic [NUM_PINS-1:0]     rise_en;
    logic [NUM_PINS-1:0]     fall_en;
    logic [NUM_PINS-1:0]     alt_q;
    logic [NUM_PINS-1:0]     latch_q;
    logic [NUM_PINS-1:0]     edge_evt;
    logic [NUM_PINS-1:0]     stat_q;
    logic                    stat_clr_we;
    logic [NUM_IRQ-1:0]      irq_w;
    logic [NUM_PINS-1:0]     rd_pins;

    // Purpose: split the address into a range check and a register index.
    always_comb begin
        addr_ok    = (bus_addr >> IDX_W) == '0;
        reg_idx    = gpio_reg_e'(bus_addr[IDX_W-1:0]);
        wdata_pins = bus_wdata[NUM_PINS-1:0];
    end

    if (DATA_W > NUM_PINS) begin : g_wdata_hi
        assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];
    end else begin : g_wdata_full
        assign unused_wdata_hi = 1'b0;
    end

    // Purpose: decode one write strobe per writable register.
    always_comb begin
        wr_sel      = '0;
        if (bus_we && addr_ok) begin
            unique case (reg_idx)
                REG_DIR:  wr_sel.dir  = 1'b1;
                REG_SET:  wr_sel.set  = 1'b1;
                REG_CLR:  wr_sel.clr  = 1'b1;
                REG_RISE: wr_sel.rise = 1'b1;
                REG_FALL: wr_sel.fall = 1'b1;
                REG_STAT: wr_sel.stat = 1'b1;
                REG_ALT:  wr_sel.alt  = 1'b1;
                default:  ;
            endcase
        end
        stat_clr_we = wr_sel.stat;
    end

    gpio_in_sync #(
        .WIDTH(NUM_PINS)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    gpio_cfg_regs #(
        .WIDTH(NUM_PINS)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .wdata     (wdata_pins),
        .dir       (dir_q),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .alt_sel   (alt_q),
        .out_latch (latch_q)
    );

    gpio_edge_capture #(
        .WIDTH(NUM_PINS)
    ) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl_sync),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_we   (stat_clr_we),
        .clr_mask (wdata_pins),
        .edge_evt (edge_evt),
        .status   (stat_q)
    );

    gpio_irq_fanin #(
        .WIDTH      (NUM_PINS),
        .NUM_DIRECT (NUM_DIRECT)
    ) irq_i (
        .status (stat_q),
        .irq    (irq_w)
    );

    assign irq = irq_w;

    // Purpose: per pin, choose the GPIO or the alternate-function drive.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        assign pin_oe[p]  = alt_q[p] ? alt_oe[p]  : dir_q[p];
        assign pin_out[p] = alt_q[p] ? alt_out[p] : latch_q[p];
    end

    // Purpose: select the read word; write-only and unmapped words read 0.
    always_comb begin
        rd_pins = '0;
        if (addr_ok) begin
            unique case (reg_idx)
                REG_LEVEL: rd_pins = lvl_sync;
                REG_DIR:   rd_pins = dir_q;
                REG_RISE:  rd_pins = rise_en;
                REG_FALL:  rd_pins = fall_en;
                REG_STAT:  rd_pins = stat_q;
                REG_ALT:   rd_pins = alt_q;
                default:   rd_pins = '0;
            endcase
        end
        bus_rdata = DATA_W'(rd_pins);
    end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Module: gpio_edge_irq_chk
// Assertion checker bound to gpio_edge_irq_ctrl. Relates the status word,
// the detected edges, the clear writes and the interrupt and pad outputs.
module gpio_edge_irq_chk #(
    parameter int NUM_PINS   = 28,
    parameter int NUM_DIRECT = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_DIRECT:0] irq,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] alt_q,
    input logic [NUM_PINS-1:0] stat_q,
    input logic [NUM_PINS-1:0] edge_evt,
    input logic                stat_clr_we,
    input logic [NUM_PINS-1:0] wdata_pins
);

    // A status bit only turns on after an edge was seen on that pin.
    assert_status_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((stat_q & ~$past(stat_q) & ~$past(edge_evt)) == '0));

    // Every detected edge is present in the status word one cycle later, clear or not.
    assert_edge_not_lost_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_evt) != '0) |-> ((stat_q & $past(edge_evt)) == $past(edge_evt)));

    // A status bit only turns off where a clear write carried a one.
    assert_clear_only_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((($past(stat_q) & ~stat_q)
                   & ~($past(stat_clr_we) ? $past(wdata_pins) : '0)) == '0));

    // Dedicated lines follow their pin's status.
    assert_direct_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq[NUM_DIRECT-1:0] == stat_q[NUM_DIRECT-1:0]);

    // The shared line reflects any status bit among the upper pins.
    assert_shared_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq[NUM_DIRECT] == (stat_q[NUM_PINS-1:NUM_DIRECT] != '0));

    // Pads not given to the alternate function follow their direction bit.
    assert_gpio_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ dir_q) & ~alt_q) == '0);

endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(
    .NUM_PINS   (NUM_PINS),
    .NUM_DIRECT (NUM_DIRECT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .pin_oe      (pin_oe),
    .dir_q       (dir_q),
    .alt_q       (alt_q),
    .stat_q      (stat_q),
    .edge_evt    (edge_evt),
    .stat_clr_we (stat_clr_we),
    .wdata_pins  (wdata_pins)
);

// File: tb/gpio_edge_irq_ctrl_tb_top.sv
// Bench: sweeps every pin and enable setting and computes the expected
// status and interrupt values from the pin number and the mode.
module gpio_edge_irq_ctrl_tb_top;

    localparam int NP = 28;
    localparam int ND = 11;
    localparam logic [3:0] A_LEVEL = 4'd0, A_DIR = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
                           A_RISE = 4'd4, A_FALL = 4'd5, A_STAT = 4'd6, A_ALT = 4'd7;
    localparam logic [31:0] PMASK = 32'h0FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] alt_out = '0;
    logic [NP-1:0] alt_oe = '0;
    logic [ND:0]   irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] irq_of(input logic [31:0] st);
        logic [31:0] r;
        r = st & 32'h0000_07FF;
        if ((st & 32'h0FFF_F800) != 0) r |= 32'h0000_0800;
        return r;
    endfunction

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] bit_p;
        logic [31:0] exp_st;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[3:0], v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 reset oe", {4'h0, pin_oe}, 32'h0);
        check("R1 reset out", {4'h0, pin_out}, 32'h0);
        check("R1 reset irq", {20'h0, irq}, 32'h0);

        // R2: readback and bit masking
        wr(A_DIR, 32'hFFFF_FFFF);  rd(A_DIR, v);  check("R2 dir", v, PMASK);
        wr(A_RISE, 32'h1234_5678); rd(A_RISE, v); check("R2 rise", v, 32'h0234_5678);
        wr(A_FALL, 32'h8765_4321); rd(A_FALL, v); check("R2 fall", v, 32'h0765_4321);
        wr(A_ALT, 32'hF0F0_0F0F);  rd(A_ALT, v);  check("R2 alt", v, 32'h00F0_0F0F);
        wr(A_ALT, 32'h0);
        wr(A_RISE, 32'h0); wr(A_FALL, 32'h0);
        wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, v); check("R2 unmapped read", v, 32'h0);
        rd(A_DIR, v); check("R2 unmapped write ignored", v, PMASK);
        check("R2 unmapped write no latch", {4'h0, pin_out}, 32'h0);

        // R3/R4: set and clear masks, outputs follow latch and direction
        wr(A_SET, 32'h00F0_F0F0);
        check("R3 set", {4'h0, pin_out}, 32'h00F0_F0F0);
        rd(A_SET, v); check("R2 set reads zero", v, 32'h0);
        wr(A_SET, 32'h0000_0001);
        check("R3 set merges", {4'h0, pin_out}, 32'h00F0_F0F1);
        wr(A_CLR, 32'h0000_00F1);
        check("R3 clear", {4'h0, pin_out}, 32'h00F0_F000);
        wr(A_CLR, 32'h0);
        check("R3 clear zero", {4'h0, pin_out}, 32'h00F0_F000);
        wr(A_SET, 32'h0);
        check("R3 set zero", {4'h0, pin_out}, 32'h00F0_F000);
        rd(A_CLR, v); check("R2 clr reads zero", v, 32'h0);
        wr(A_DIR, 32'h0555_AAAA);
        check("R4 oe follows dir", {4'h0, pin_oe}, 32'h0555_AAAA);

        // R5: alternate bypass
        alt_oe = 28'h00000F0; alt_out = 28'h0000033;
        wr(A_ALT, 32'h0000_00FF);
        check("R5 alt oe", {4'h0, pin_oe}, (32'h0555_AAAA & ~32'hFF) | 32'h0000_00F0);
        check("R5 alt out", {4'h0, pin_out}, (32'h00F0_F000 & ~32'hFF) | 32'h0000_0033);
        wr(A_ALT, 32'h0);
        check("R4 back to gpio", {4'h0, pin_out}, 32'h00F0_F000);

        // R6: level read through the synchronizer
        pin_in = 28'hA5C3F09;
        idle(3);
        rd(A_LEVEL, v); check("R6 level", v, 32'h0A5C_3F09);
        pin_in = 28'h0;
        idle(3);
        rd(A_LEVEL, v); check("R6 level low", v, 32'h0);
        rd(A_STAT, v);  check("R8 no enables no status", v, 32'h0);

        // R7/R8/R11/R12: every pin, every enable mode, rise then fall
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                bit_p = 32'h1 << p;
                wr(A_RISE, m[0] ? bit_p : 32'h0);
                wr(A_FALL, m[1] ? bit_p : 32'h0);
                pin_in[p] = 1'b1;
                idle(4);
                exp_st = m[0] ? bit_p : 32'h0;
                rd(A_STAT, v); check("R7 rise capture", v, exp_st);
                check("R11 R12 irq after rise", {20'h0, irq}, irq_of(exp_st));
                pin_in[p] = 1'b0;
                idle(4);
                exp_st = (m != 0) ? bit_p : 32'h0;
                rd(A_STAT, v); check("R7 fall capture", v, exp_st);
                check("R11 R12 irq after fall", {20'h0, irq}, irq_of(exp_st));
                wr(A_STAT, bit_p);
                rd(A_STAT, v); check("R9 clear pin", v, 32'h0);
            end
        end

        // R12: shared line stays up while any upper pin is pending
        wr(A_RISE, 32'h0800_0800); wr(A_FALL, 32'h0);
        pin_in[11] = 1'b1; pin_in[27] = 1'b1;
        idle(4);
        rd(A_STAT, v); check("R7 two upper pins", v, 32'h0800_0800);
        check("R12 shared on", {20'h0, irq}, 32'h0000_0800);
        wr(A_STAT, 32'h0800_0000);
        check("R12 shared still on", {20'h0, irq}, 32'h0000_0800);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R9 zero write keeps", v, 32'h0000_0800);
        wr(A_STAT, 32'h0000_0800);
        check("R12 shared off", {20'h0, irq}, 32'h0);
        pin_in[11] = 1'b0; pin_in[27] = 1'b0;
        idle(4);

        // R8: dropping the enable keeps a pending bit
        wr(A_RISE, 32'h0000_0020);
        pin_in[5] = 1'b1; idle(4);
        wr(A_RISE, 32'h0);
        rd(A_STAT, v); check("R8 status kept after disable", v, 32'h0000_0020);
        check("R11 line kept after disable", {20'h0, irq}, 32'h0000_0020);
        pin_in[5] = 1'b0; idle(4);
        wr(A_STAT, 32'h0000_0020);

        // R10: a fall arrives in the same cycle the clear is written
        wr(A_RISE, 32'h0000_1000); wr(A_FALL, 32'h0000_1000);
        pin_in[12] = 1'b1; idle(4);
        rd(A_STAT, v); check("R10 setup", v, 32'h0000_1000);
        @(negedge clk); pin_in[12] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 32'h0000_1000; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(A_STAT, v); check("R10 edge beats clear", v, 32'h0000_1000);
        check("R10 shared line held", {20'h0, irq}, 32'h0000_0800);
        wr(A_STAT, 32'h0000_1000);
        rd(A_STAT, v); check("R9 clear after collision", v, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule